// File: doc/BRIEF.md
# Left-Justified Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a word clock that tells left from right, and a data line. The framing is left-justified. The first bit of each word is on the line at the first bit-clock rising edge after the word clock changes level, with no extra bit of delay. The word clock is high for the left channel and low for the right channel. The block runs entirely in the bit-clock domain: its `clk` input is the serial bit clock, and the word clock and data are sampled on its rising edges.

Each serial word is assembled MSB first into a 24-bit parallel sample. A static configuration input sets the word length, from 16 to 24 bits. Bits after the configured length are dropped, and unused low bits of the sample are zero. A half-frame is closed by the next word-clock edge. On the cycle after that edge the sample appears with a one-cycle valid strobe and a channel tag. If the edge arrives before the configured number of bits, the partial word is still delivered, zero-padded, and a short-word flag is raised with the strobe.

The controller is a four-state machine:
- `ST_SYNC` samples the word-clock level once after reset, then always moves to `ST_ARM`.
- `ST_ARM` waits for the first word-clock edge and emits nothing.
  - Edge: it captures the MSB and moves to `ST_SHIFT`.
- `ST_SHIFT` collects bits.
  - Edge: it emits the word as short and restarts in `ST_SHIFT`.
  - Last configured bit collected: it moves to `ST_FULL`.
- `ST_FULL` ignores further bits.
  - Edge: it emits the word as complete and restarts in `ST_SHIFT`.

Top module: `lj_audio_rx`

## Requirements
- R1: Data is taken MSB first. The bit present at the first rising edge after a word-clock transition, in either direction, becomes bit 23 of the sample. Each following bit lands one position lower.
- R2: `smp_left_o` is 1 for a word received while the word clock was high, and 0 for one received while it was low.
- R3: `smp_valid_o` is high for exactly one cycle per half-frame. That cycle is the one after the rising edge at which the word-clock edge that ends the half-frame is seen. `smp_data_o`, `smp_left_o` and `smp_short_o` are valid in that cycle.
- R4: The effective word length L is taken from `word_len_i`. Values from 16 to 24 are used as given, values below 16 act as 16, and values above 24 act as 24. Bits beyond the L-th of a half-frame have no effect on the sample.
- R5: In a sample, bits 23 down to 24-L carry the received bits and all lower bits are 0.
- R6: A half-frame with n < L bits is still delivered. Its n received bits fill bits 23 down to 24-n, the rest are 0, and `smp_short_o` is 1 in the valid cycle. `smp_short_o` is 0 for a half-frame of L or more bits and whenever `smp_valid_o` is 0.
- R7: During and after reset all outputs are 0. The word-clock level in the first cycle after reset is the reference. No sample is emitted for bits before the first word-clock edge. The half-frame started by that edge is the first one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk_i | input | 1 | Word clock: high = left, low = right |
| sdata_i | input | 1 | Serial data, MSB first |
| word_len_i | input | 5 | Static word length in bits (clamped to 16..24) |
| smp_data_o | output | 24 | Assembled sample, MSB aligned, zero padded |
| smp_valid_o | output | 1 | One-cycle strobe for a delivered sample |
| smp_left_o | output | 1 | Channel tag of the delivered sample (1 = left) |
| smp_short_o | output | 1 | Word ended before the configured length |

## Verification
An error in the bit counter or in the state register shows up in the very next delivered sample. A wrong shift position or a missed `ST_FULL` transition leaves received bits out of place or lets bits past length L leak into the zero padding. The pad region and the short flag are checked on every strobe. A stale edge register gives the wrong channel tag, or a strobe one cycle early or late. Because the bench expects silence or a strobe on every single cycle, a misplaced pulse is reported within one bit period. Half-frame lengths span 1 to 32 bits against clamped and unclamped lengths, so every state transition is taken many times.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_FULL  = 2'd3
    } rx_state_e;

    // Mask with the top n of w bits set (w <= 32).
    function automatic logic [31:0] top_mask(input int n, input int w);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < w && i >= w - n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lj_wclk_edge.sv
module lj_wclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_i,
    output logic level_q,
    output logic edge_seen
);

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= wclk_i;
    end

    assign edge_seen = wclk_i ^ level_q;

endmodule

// File: rtl/lj_word_asm.sv
module lj_word_asm #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift_en,
    input  logic              sdata,
    output logic [DATA_W-1:0] word,
    output logic [CNT_W-1:0]  count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            count <= '0;
        end else if (start) begin
            word  <= {sdata, {(DATA_W-1){1'b0}}};
            count <= CNT_W'(1);
        end else if (shift_en) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (i == DATA_W - 1 - int'(count)) word[i] <= sdata;
            end
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lj_audio_rx.sv
module lj_audio_rx
    import lj_rx_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int LEN_W   = 5,
    parameter int MIN_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wclk_i,
    input  logic              sdata_i,
    input  logic [LEN_W-1:0]  word_len_i,
    output logic [DATA_W-1:0] smp_data_o,
    output logic              smp_valid_o,
    output logic              smp_left_o,
    output logic              smp_short_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    rx_state_e          state, state_nxt;
    logic               level_q, edge_seen;
    logic               start, shift_en, emit;
    logic [DATA_W-1:0]  word;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   len_eff;

    // Effective word length, clamped to MIN_LEN..DATA_W
    always_comb begin
        if (int'(word_len_i) < MIN_LEN)      len_eff = CNT_W'(MIN_LEN);
        else if (int'(word_len_i) > DATA_W)  len_eff = CNT_W'(DATA_W);
        else                                 len_eff = CNT_W'(word_len_i);
    end

    lj_wclk_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wclk_i    (wclk_i),
        .level_q   (level_q),
        .edge_seen (edge_seen)
    );

    assign start    = edge_seen && (state != ST_SYNC);
    assign shift_en = (state == ST_SHIFT) && !edge_seen;
    assign emit     = edge_seen && (state == ST_SHIFT || state == ST_FULL);

    lj_word_asm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .shift_en (shift_en),
        .sdata    (sdata_i),
        .word     (word),
        .count    (count)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SYNC;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SYNC:  state_nxt = ST_ARM;
            ST_ARM:   if (edge_seen) state_nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (edge_seen)                        state_nxt = ST_SHIFT;
                else if (count + CNT_W'(1) >= len_eff) state_nxt = ST_FULL;
            end
            ST_FULL:  if (edge_seen) state_nxt = ST_SHIFT;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_data_o  <= '0;
            smp_valid_o <= 1'b0;
            smp_left_o  <= 1'b0;
            smp_short_o <= 1'b0;
        end else begin
            smp_valid_o <= emit;
            smp_short_o <= emit && (state == ST_SHIFT);
            if (emit) begin
                smp_data_o <= word;
                smp_left_o <= level_q;
            end
        end
    end

    AST_SHORT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        smp_short_o |-> smp_valid_o); // R6

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && !smp_short_o) |->
            ((32'(smp_data_o) & ~top_mask(int'(len_eff), DATA_W)) == 32'd0)); // R5

    AST_TAG_PREV_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (smp_left_o != level_q)); // R2

    AST_QUIET_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC || state == ST_ARM) |=> !smp_valid_o); // R7

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= len_eff); // R4

endmodule

// File: tb/lj_audio_rx_tb.sv
module lj_audio_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic [4:0]  word_len_i = 5'd24;
    logic [23:0] smp_data_o;
    logic        smp_valid_o, smp_left_o, smp_short_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit          have_cur;
    bit          cur_level;
    int          cur_n;
    logic [31:0] cur_pay;
    bit          pend;
    logic [23:0] exp_data;
    bit          exp_left, exp_short;

    always #10 clk = ~clk;

    lj_audio_rx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wclk_i      (wclk_i),
        .sdata_i     (sdata_i),
        .word_len_i  (word_len_i),
        .smp_data_o  (smp_data_o),
        .smp_valid_o (smp_valid_o),
        .smp_left_o  (smp_left_o),
        .smp_short_o (smp_short_o)
    );

    function automatic int eff_len(input logic [4:0] cfg);
        if (cfg < 5'd16) return 16;
        if (cfg > 5'd24) return 24;
        return int'(cfg);
    endfunction

    function automatic logic [23:0] model_data(input logic [31:0] pay, input int n, input int len);
        logic [23:0] r;
        int take;
        r = '0;
        take = (n < len) ? n : len;
        for (int i = 0; i < take; i++) r[23-i] = pay[31-i];
        return r;
    endfunction

    task automatic fail_msg(input string req, input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    endtask

    task automatic check_out();
        checks++;
        if (smp_valid_o !== pend) fail_msg("R3 valid", 32'(smp_valid_o), 32'(pend));
        else if (pend) begin
            checks++;
            if (smp_data_o !== exp_data) fail_msg("R1 R4 R5 data", 32'(smp_data_o), 32'(exp_data));
            checks++;
            if (smp_left_o !== exp_left) fail_msg("R2 tag", 32'(smp_left_o), 32'(exp_left));
            checks++;
            if (smp_short_o !== exp_short) fail_msg("R6 short", 32'(smp_short_o), 32'(exp_short));
        end else if (smp_short_o !== 1'b0) begin
            fail_msg("R6 short without valid", 32'(smp_short_o), 32'd0);
        end
    endtask

    task automatic drive_bit(input bit level, input bit b);
        @(negedge clk);
        check_out();
        pend = 1'b0;
        if (level != cur_level) begin
            if (have_cur) begin
                pend      = 1'b1;
                exp_data  = model_data(cur_pay, cur_n, eff_len(word_len_i));
                exp_left  = cur_level;
                exp_short = (cur_n < eff_len(word_len_i));
            end
            have_cur = 1'b1;
            cur_n    = 0;
            cur_pay  = '0;
        end
        if (have_cur) begin
            if (cur_n < 32) cur_pay[31-cur_n] = b;
            cur_n++;
        end
        cur_level = level;
        wclk_i    = level;
        sdata_i   = b;
    endtask

    task automatic send_half(input bit level, input int n, input logic [31:0] pay);
        for (int i = 0; i < n; i++) drive_bit(level, pay[31-i]);
    endtask

    task automatic do_reset(input logic [4:0] cfg, input bit level);
        @(negedge clk);
        rst_n      = 1'b0;
        word_len_i = cfg;
        wclk_i     = level;
        sdata_i    = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (smp_valid_o !== 1'b0 || smp_data_o !== 24'd0 || smp_left_o !== 1'b0 || smp_short_o !== 1'b0)
            fail_msg("R7 reset outputs", {smp_valid_o, smp_left_o, smp_short_o, 5'd0, smp_data_o}, 32'd0);
        rst_n     = 1'b1;
        have_cur  = 1'b0;
        pend      = 1'b0;
        cur_level = level;
        // bits before the first edge must never be delivered (R7)
        send_half(level, 3, 32'hFFFF_FFFF);
    endtask

    initial begin
        bit lvl;
        void'($urandom(32'd20240611));

        // R1 R5: exact length 16, both edge directions
        do_reset(5'd16, 1'b0);
        send_half(1'b1, 16, 32'hA5C3_0000);
        send_half(1'b0, 16, 32'h8001_0000);
        // R6: short word of 15 bits, then 1-bit word
        send_half(1'b1, 15, 32'hFFFF_FFFF);
        send_half(1'b0, 1, 32'h8000_0000);
        // R4: extra bits beyond length ignored
        send_half(1'b1, 24, 32'h1234_56FF);
        send_half(1'b0, 2, 32'h4000_0000);

        // R5 full 24-bit words, R6 23-bit short
        do_reset(5'd24, 1'b1);
        send_half(1'b0, 24, 32'hDEAD_BE00);
        send_half(1'b1, 23, 32'hFFFF_FFFF);
        send_half(1'b0, 24, 32'h0000_0100);
        send_half(1'b1, 4, 32'h0);

        // R4 clamping: 5 acts as 16, 31 acts as 24
        do_reset(5'd5, 1'b0);
        send_half(1'b1, 20, 32'hFFFF_F000);
        send_half(1'b0, 15, 32'hFFFF_FFFF);
        send_half(1'b1, 3, 32'h0);
        do_reset(5'd31, 1'b1);
        send_half(1'b0, 30, 32'hFFFF_FFFF);
        send_half(1'b1, 24, 32'h5555_5555);
        send_half(1'b0, 3, 32'h0);

        // random frames over random lengths
        for (int cfgi = 0; cfgi < 6; cfgi++) begin
            lvl = 1'($urandom_range(0, 1));
            do_reset(5'($urandom_range(0, 31)), lvl);
            for (int h = 0; h < 40; h++) begin
                lvl = ~lvl;
                if ($urandom_range(0, 3) == 0) send_half(lvl, $urandom_range(1, 32), $urandom);
                else send_half(lvl, $urandom_range(14, 26), $urandom);
            end
            send_half(~lvl, 2, 32'h0);
        end

        drive_bit(cur_level, 1'b0);
        drive_bit(cur_level, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule